// File: doc/BRIEF.md
# DSP Core Power-Up Boot Sequencer

This block is a hardware state machine that takes an embedded DSP core from power-down to running. On a start pulse, accepted only while the power-good input is high, it latches the boot address and the strap values. It then walks through a fixed series of steps. First it sets a temporary clock-gating override and releases the subsystem reset. Next it loads the boot vector and the memory and bus-window straps. It then stops the core clock, clamps the IO and puts the memories to sleep, and holds the core reset lines. After that it wakes the memories, restarts the core clock and removes the clamp. Finally it releases the core and, after a minimum delay, drops the clock-gating override.

Each step updates the registered outputs on one clock edge. The reset hold and the delay before the gating override is released are parameters counted in the sequencer clock. If power good falls at any point in the sequence, the block returns to idle with every reset asserted and the clamp set. Once a boot completes, the outputs keep the running configuration until the next start, abort or reset.

Top module: `dsp_boot_seq`

## Requirements
- R1: During and after synchronous reset: subsystem reset 1, all four core resets 1, clamp 1, memory enables 0, core clock enable 0, source override 0, gating override 0, boot vector and both straps 0, busy 0, done 0.
- R2: A start pulse is accepted only in idle with power good high. The gating override and busy both rise one cycle after the accepting edge.
- R3: The subsystem reset falls one cycle after the gating override rises, and all four core resets stay 1 while it is low before release.
- R4: One cycle later the boot vector equals bits [31:8] of the address latched at acceptance.
- R5: One cycle after that, the memory strap output equals the latched memory strap, and the bus-window strap output equals the OR of the latched upper and lower fields.
- R6: Next the core clock enable goes to 0 with the source override at 1. One cycle later the clamp is 1 and all memory enables are 0.
- R7: The core resets (bit 0 core, bit 1 debug, bit 2 trace, bit 3 stop-core) stay at 1 for HOLD_CYC cycles after the memories sleep. Then all six memory enables (bit 0 L2 data, 1 L2 tag, 2 L1 TCM, 3 retention, 4 trace buffer, 5 array standby) rise together while the clamp stays at 1.
- R8: One cycle after the memories wake, the core clock enable rises with the source override at 1. One cycle later the clamp falls alone.
- R9: One cycle after the clamp falls, all core resets go to 0. The gating override falls REL_CYC cycles after that.
- R10: Done pulses high for exactly one cycle, on the cycle the gating override falls, and busy falls on the same cycle.
- R11: A start pulse that arrives while a sequence is in progress has no effect on any output.
- R12: If power good is low on any clock edge while a sequence is in progress, then on the next cycle: subsystem reset 1, core resets all 1, clamp 1, memory enables 0, clock enable 0, source override 0, gating override 0, busy 0. The block then waits in idle for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| pwr_good_i | input | 1 | Power rail and bus path ready |
| boot_addr_i | input | 32 | Core start address |
| tcm_strap_i | input | 32 | Tightly coupled memory strap value |
| busw_hi_i | input | 32 | Upper field of the bus-window strap |
| busw_lo_i | input | 32 | Lower field of the bus-window strap |
| ss_reset_o | output | 1 | Subsystem reset |
| core_rst_o | output | 4 | Core, debug, trace, stop-core resets |
| boot_vec_o | output | 24 | Boot vector, address bits [31:8] |
| tcm_strap_o | output | 32 | Memory strap to the core |
| busw_strap_o | output | 32 | Bus-window strap to the core |
| clamp_o | output | 1 | IO clamp |
| mem_en_o | output | 6 | Memory sleep, retention and standby enables |
| clk_en_o | output | 1 | Core clock enable |
| src_ovr_o | output | 1 | Clock source switch override |
| cg_ovr_o | output | 1 | Clock-gating override |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check ordering rules on every cycle. The core resets are fully set whenever the subsystem reset is set, and the clock enable only rises onto awake, clamped memories. The clamp only falls with the clock running and the memories on, and the core only leaves reset after the clamp is gone. The gating override is only dropped after a cycle with the core already released, done lasts a single cycle, and a power-good drop while busy leads to the safe state. Only the bench scenarios can show the exact cycle of each step, the length of the reset hold, and the boot vector and strap values. They also cover ignored starts and a clean boot after an abort.

// File: rtl/dsp_boot_pkg.sv
package dsp_boot_pkg;
  localparam int CORE_RST_W = 4;
  localparam int MEM_EN_W   = 6;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GATE_OVR,
    ST_SS_REL,
    ST_VECTOR,
    ST_STRAPS,
    ST_CLK_OFF,
    ST_MEM_SLEEP,
    ST_RST_HOLD,
    ST_MEM_WAKE,
    ST_CLK_ON,
    ST_UNCLAMP,
    ST_CORE_REL,
    ST_GATE_REL
  } boot_st_e;
endpackage

// File: rtl/boot_wait_timer.sv
module boot_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_o <= '0;
    else               cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/boot_ctrl_fsm.sv
module boot_ctrl_fsm
  import dsp_boot_pkg::*;
#(
  parameter int HOLD_CYC = 8,
  parameter int REL_CYC  = 1,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             pwr_good_i,
  input  logic [CNT_W-1:0] cnt_i,
  output boot_st_e         st_o,
  output logic             run_o,
  output logic             accept_o,
  output logic             abort_o
);
  boot_st_e st_next;
  logic     hold_end, rel_end;

  assign hold_end = (cnt_i == CNT_W'(HOLD_CYC - 1));
  assign rel_end  = (cnt_i == CNT_W'(REL_CYC - 1));
  assign accept_o = (st_o == ST_IDLE) && start_i && pwr_good_i;
  assign abort_o  = (st_o != ST_IDLE) && !pwr_good_i;
  assign run_o    = ((st_o == ST_RST_HOLD) && !hold_end) ||
                    ((st_o == ST_CORE_REL) && !rel_end);

  always_comb begin
    st_next = st_o;
    if (abort_o) st_next = ST_IDLE;
    else begin
      case (st_o)
        ST_IDLE:      if (accept_o) st_next = ST_GATE_OVR;
        ST_GATE_OVR:  st_next = ST_SS_REL;
        ST_SS_REL:    st_next = ST_VECTOR;
        ST_VECTOR:    st_next = ST_STRAPS;
        ST_STRAPS:    st_next = ST_CLK_OFF;
        ST_CLK_OFF:   st_next = ST_MEM_SLEEP;
        ST_MEM_SLEEP: st_next = ST_RST_HOLD;
        ST_RST_HOLD:  if (hold_end) st_next = ST_MEM_WAKE;
        ST_MEM_WAKE:  st_next = ST_CLK_ON;
        ST_CLK_ON:    st_next = ST_UNCLAMP;
        ST_UNCLAMP:   st_next = ST_CORE_REL;
        ST_CORE_REL:  if (rel_end) st_next = ST_GATE_REL;
        ST_GATE_REL:  st_next = ST_IDLE;
        default:      st_next = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_o <= ST_IDLE;
    else     st_o <= st_next;
  end
endmodule

// File: rtl/boot_drive_regs.sv
module boot_drive_regs
  import dsp_boot_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int VEC_LSB = 8,
  parameter int STRAP_W = 32,
  localparam int VEC_W  = ADDR_W - VEC_LSB
) (
  input  logic                  clk,
  input  logic                  rst,
  input  boot_st_e              st_i,
  input  logic                  accept_i,
  input  logic                  abort_i,
  input  logic [ADDR_W-1:0]     boot_addr_i,
  input  logic [STRAP_W-1:0]    tcm_strap_i,
  input  logic [STRAP_W-1:0]    busw_hi_i,
  input  logic [STRAP_W-1:0]    busw_lo_i,
  output logic                  ss_reset_o,
  output logic [CORE_RST_W-1:0] core_rst_o,
  output logic [VEC_W-1:0]      boot_vec_o,
  output logic [STRAP_W-1:0]    tcm_strap_o,
  output logic [STRAP_W-1:0]    busw_strap_o,
  output logic                  clamp_o,
  output logic [MEM_EN_W-1:0]   mem_en_o,
  output logic                  clk_en_o,
  output logic                  src_ovr_o,
  output logic                  cg_ovr_o,
  output logic                  busy_o,
  output logic                  done_o
);
  logic [VEC_W-1:0]   vec_q;
  logic [STRAP_W-1:0] tcm_q, busw_q;

  // Request values are captured at acceptance so later input changes cannot leak in.
  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q  <= '0;
      tcm_q  <= '0;
      busw_q <= '0;
    end else if (accept_i) begin
      vec_q  <= VEC_W'(boot_addr_i >> VEC_LSB);
      tcm_q  <= tcm_strap_i;
      busw_q <= busw_hi_i | busw_lo_i;
    end
  end

  // Each state applies its step on the edge that leaves it; idle holds everything.
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_reset_o   <= 1'b1;
      core_rst_o   <= '1;
      boot_vec_o   <= '0;
      tcm_strap_o  <= '0;
      busw_strap_o <= '0;
      clamp_o      <= 1'b1;
      mem_en_o     <= '0;
      clk_en_o     <= 1'b0;
      src_ovr_o    <= 1'b0;
      cg_ovr_o     <= 1'b0;
      busy_o       <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        ss_reset_o <= 1'b1;
        core_rst_o <= '1;
        clamp_o    <= 1'b1;
        mem_en_o   <= '0;
        clk_en_o   <= 1'b0;
        src_ovr_o  <= 1'b0;
        cg_ovr_o   <= 1'b0;
        busy_o     <= 1'b0;
      end else begin
        case (st_i)
          ST_IDLE:      busy_o <= 1'b0;
          ST_GATE_OVR:  begin cg_ovr_o <= 1'b1; busy_o <= 1'b1; end
          ST_SS_REL:    ss_reset_o <= 1'b0;
          ST_VECTOR:    boot_vec_o <= vec_q;
          ST_STRAPS:    begin tcm_strap_o <= tcm_q; busw_strap_o <= busw_q; end
          ST_CLK_OFF:   begin clk_en_o <= 1'b0; src_ovr_o <= 1'b1; end
          ST_MEM_SLEEP: begin clamp_o <= 1'b1; mem_en_o <= '0; end
          ST_RST_HOLD:  core_rst_o <= '1;
          ST_MEM_WAKE:  begin mem_en_o <= '1; clamp_o <= 1'b1; end
          ST_CLK_ON:    begin clk_en_o <= 1'b1; src_ovr_o <= 1'b1; end
          ST_UNCLAMP:   clamp_o <= 1'b0;
          ST_CORE_REL:  begin core_rst_o <= '0; ss_reset_o <= 1'b0; end
          ST_GATE_REL:  begin cg_ovr_o <= 1'b0; done_o <= 1'b1; busy_o <= 1'b0; end
          default:      busy_o <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dsp_boot_seq.sv
module dsp_boot_seq
  import dsp_boot_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int VEC_LSB  = 8,
  parameter int STRAP_W  = 32,
  parameter int HOLD_CYC = 8,
  parameter int REL_CYC  = 1,
  localparam int VEC_W    = ADDR_W - VEC_LSB,
  localparam int WAIT_MAX = (HOLD_CYC > REL_CYC) ? HOLD_CYC : REL_CYC,
  localparam int CNT_W    = $clog2(WAIT_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic                  pwr_good_i,
  input  logic [ADDR_W-1:0]     boot_addr_i,
  input  logic [STRAP_W-1:0]    tcm_strap_i,
  input  logic [STRAP_W-1:0]    busw_hi_i,
  input  logic [STRAP_W-1:0]    busw_lo_i,
  output logic                  ss_reset_o,
  output logic [CORE_RST_W-1:0] core_rst_o,
  output logic [VEC_W-1:0]      boot_vec_o,
  output logic [STRAP_W-1:0]    tcm_strap_o,
  output logic [STRAP_W-1:0]    busw_strap_o,
  output logic                  clamp_o,
  output logic [MEM_EN_W-1:0]   mem_en_o,
  output logic                  clk_en_o,
  output logic                  src_ovr_o,
  output logic                  cg_ovr_o,
  output logic                  busy_o,
  output logic                  done_o
);
  boot_st_e         st;
  logic             run, accept, abort_seq;
  logic [CNT_W-1:0] cnt;

  boot_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .run_i(run), .cnt_o(cnt)
  );

  boot_ctrl_fsm #(.HOLD_CYC(HOLD_CYC), .REL_CYC(REL_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .pwr_good_i(pwr_good_i),
    .cnt_i(cnt), .st_o(st), .run_o(run), .accept_o(accept), .abort_o(abort_seq)
  );

  boot_drive_regs #(.ADDR_W(ADDR_W), .VEC_LSB(VEC_LSB), .STRAP_W(STRAP_W)) u_regs (
    .clk(clk), .rst(rst), .st_i(st), .accept_i(accept), .abort_i(abort_seq),
    .boot_addr_i(boot_addr_i), .tcm_strap_i(tcm_strap_i),
    .busw_hi_i(busw_hi_i), .busw_lo_i(busw_lo_i),
    .ss_reset_o(ss_reset_o), .core_rst_o(core_rst_o), .boot_vec_o(boot_vec_o),
    .tcm_strap_o(tcm_strap_o), .busw_strap_o(busw_strap_o), .clamp_o(clamp_o),
    .mem_en_o(mem_en_o), .clk_en_o(clk_en_o), .src_ovr_o(src_ovr_o),
    .cg_ovr_o(cg_ovr_o), .busy_o(busy_o), .done_o(done_o)
  );
endmodule

// File: rtl/dsp_boot_seq_chk.sv
module dsp_boot_seq_chk
  import dsp_boot_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  pwr_good_i,
  input logic                  ss_reset_o,
  input logic [CORE_RST_W-1:0] core_rst_o,
  input logic                  clamp_o,
  input logic [MEM_EN_W-1:0]   mem_en_o,
  input logic                  clk_en_o,
  input logic                  cg_ovr_o,
  input logic                  busy_o,
  input logic                  done_o
);
  AST_CORE_HELD_WITH_SS: assert property (@(posedge clk) disable iff (rst)
    ss_reset_o |-> (core_rst_o == '1)); // R3

  AST_CLK_ON_AWAKE_MEM: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_o) |-> ((mem_en_o == '1) && clamp_o)); // R8

  AST_UNCLAMP_RUNNING: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_o) |-> (clk_en_o && (mem_en_o == '1))); // R8

  AST_RELEASE_UNCLAMPED: assert property (@(posedge clk) disable iff (rst)
    $fell(core_rst_o[0]) |-> (!clamp_o && clk_en_o && !ss_reset_o)); // R9

  AST_GATE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(cg_ovr_o) && !ss_reset_o) |-> ($past(core_rst_o) == '0)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !cg_ovr_o)); // R10

  AST_ABORT_SAFE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !pwr_good_i) |=> (ss_reset_o && clamp_o && !busy_o && !clk_en_o)); // R12
endmodule

bind dsp_boot_seq dsp_boot_seq_chk u_chk (
  .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .ss_reset_o(ss_reset_o),
  .core_rst_o(core_rst_o), .clamp_o(clamp_o), .mem_en_o(mem_en_o),
  .clk_en_o(clk_en_o), .cg_ovr_o(cg_ovr_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/test_dsp_boot_seq.sv
`timescale 1ns/1ps
module test_dsp_boot_seq;
  localparam int H = 8;
  localparam int R = 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, pg = 1'b0;
  logic [31:0] addr = '0, tcm = '0, bhi = '0, blo = '0;
  logic ss, clamp, clken, src, cg, busy, done;
  logic [3:0] core;
  logic [23:0] vec;
  logic [31:0] tcm_o, busw_o;
  logic [5:0] mem;

  int checks = 0, fails = 0, done_cnt = 0;

  always #2 clk = ~clk;

  dsp_boot_seq #(.HOLD_CYC(H), .REL_CYC(R)) i_dsp_boot_seq (
    .clk(clk), .rst(rst), .start_i(start), .pwr_good_i(pg), .boot_addr_i(addr),
    .tcm_strap_i(tcm), .busw_hi_i(bhi), .busw_lo_i(blo), .ss_reset_o(ss),
    .core_rst_o(core), .boot_vec_o(vec), .tcm_strap_o(tcm_o), .busw_strap_o(busw_o),
    .clamp_o(clamp), .mem_en_o(mem), .clk_en_o(clken), .src_ovr_o(src),
    .cg_ovr_o(cg), .busy_o(busy), .done_o(done)
  );

  // Reference model: schedule of port values counted from the accepting edge.
  logic e_ss, e_clamp, e_clk, e_src, e_cg, e_busy, e_done;
  logic [3:0] e_core;
  logic [23:0] e_vec, m_vec;
  logic [31:0] e_tcm, e_busw, m_tcm, m_busw;
  logic [5:0] e_mem;
  bit active = 0;
  int t = 0;

  always @(posedge clk) begin
    if (rst) begin
      e_ss = 1; e_core = 4'hF; e_vec = 0; e_tcm = 0; e_busw = 0; e_clamp = 1;
      e_mem = 0; e_clk = 0; e_src = 0; e_cg = 0; e_busy = 0; e_done = 0;
      active = 0; t = 0;
    end else if (active && !pg) begin
      e_ss = 1; e_core = 4'hF; e_clamp = 1; e_mem = 0; e_clk = 0; e_src = 0;
      e_cg = 0; e_busy = 0; e_done = 0; active = 0;
    end else if (active) begin
      t++;
      if (t == 1) begin e_cg = 1; e_busy = 1; end
      if (t == 2) e_ss = 0;
      if (t == 3) e_vec = m_vec;
      if (t == 4) begin e_tcm = m_tcm; e_busw = m_busw; end
      if (t == 5) begin e_clk = 0; e_src = 1; end
      if (t == 6) begin e_clamp = 1; e_mem = 0; end
      if (t >= 7 && t <= 6 + H) e_core = 4'hF;
      if (t == 7 + H) begin e_mem = 6'h3F; e_clamp = 1; end
      if (t == 8 + H) begin e_clk = 1; e_src = 1; end
      if (t == 9 + H) e_clamp = 0;
      if (t >= 10 + H && t <= 9 + H + R) begin e_core = 0; e_ss = 0; end
      if (t == 10 + H + R) begin e_cg = 0; e_done = 1; e_busy = 0; active = 0; end
    end else begin
      e_done = 0;
      if (start && pg) begin
        active = 1; t = 0;
        m_vec = addr[31:8]; m_tcm = tcm; m_busw = bhi | blo;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", 32'(busy), 32'(e_busy));
      chk("R2/R9 gating override", 32'(cg), 32'(e_cg));
      chk("R3 subsystem reset", 32'(ss), 32'(e_ss));
      chk("R7 core resets", 32'(core), 32'(e_core));
      chk("R4 boot vector", 32'(vec), 32'(e_vec));
      chk("R5 memory strap", tcm_o, e_tcm);
      chk("R5 bus-window strap", busw_o, e_busw);
      chk("R6/R8 clock enable", 32'(clken), 32'(e_clk));
      chk("R6 source override", 32'(src), 32'(e_src));
      chk("R8 clamp", 32'(clamp), 32'(e_clamp));
      chk("R7 memory enables", 32'(mem), 32'(e_mem));
      chk("R10 done", 32'(done), 32'(e_done));
      if (done) done_cnt++;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kick(input logic [31:0] a, input logic [31:0] m, input logic [31:0] hi,
                      input logic [31:0] lo);
    @(negedge clk);
    addr = a; tcm = m; bhi = hi; blo = lo; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(4);
    rst = 0;
    cyc(1);
    // R1 reset state
    chk("R1 ss", 32'(ss), 1); chk("R1 core", 32'(core), 32'hF);
    chk("R1 clamp", 32'(clamp), 1); chk("R1 mem", 32'(mem), 0);
    chk("R1 busy", 32'(busy), 0); chk("R1 cg", 32'(cg), 0);
    // R2: start without power good is ignored
    kick(32'h1234_5678, 32'h0002_0000, 32'hA000_0000, 32'h0000_00C3);
    cyc(4);
    chk("R2 no start without power good", 32'(busy), 0);
    // Full boot with extra start pulses while busy (R11)
    pg = 1;
    kick(32'h1234_5678, 32'h0002_0000, 32'hA000_0000, 32'h0000_00C3);
    cyc(3);
    kick(32'hDEAD_BEEF, 32'h1, 32'h2, 32'h4);
    cyc(5);
    kick(32'h0BAD_F00D, 32'h8, 32'h10, 32'h20);
    cyc(25);
    chk("R4 final vector", 32'(vec), 32'h0012_3456);
    chk("R5 final bus window", busw_o, 32'hA000_00C3);
    chk("R11 one done per boot", 32'(done_cnt), 1);
    chk("R9 core running", 32'(core), 0);
    // Second boot aborted during the reset hold (R12)
    kick(32'hFFFF_FFFF, 32'h5555_0000, 32'h0F00_0000, 32'h0000_00F0);
    cyc(9);
    pg = 0;
    cyc(1);
    chk("R12 abort subsystem reset", 32'(ss), 1);
    chk("R12 abort core resets", 32'(core), 32'hF);
    chk("R12 abort clamp", 32'(clamp), 1);
    chk("R12 abort idle", 32'(busy), 0);
    pg = 1;
    cyc(3);
    chk("R12 stays idle", 32'(busy), 0);
    // Third boot after abort
    kick(32'h0000_01FF, 32'h0000_4000, 32'h0, 32'h0000_0011);
    cyc(25);
    chk("R4 vector after abort", 32'(vec), 32'h0000_0001);
    chk("R10 done count", 32'(done_cnt), 2);
    summary();
  end
endmodule